// File: doc/BRIEF.md
# SPI Flash Command Framing Front End

This block is the slave-side command front end of a serial NOR flash. It watches chip select, serial clock and serial data from the host, assembles incoming bits into bytes (most significant bit first) and treats the first byte of each chip-select-low frame as the opcode. Depending on the opcode, the following bytes are routed into a 24-bit address register, presented as data-byte strobes, or simply counted. For read-type opcodes it then streams bytes supplied by the array side back out on the serial output.

When chip select returns high, the block issues exactly one verdict pulse for the frame: execute or reject. Commands that modify state (write enable and disable, status write, page program, sector, block and chip erase) are accepted only when the clock count of the frame is a nonzero multiple of eight and the frame carried every byte that the opcode needs. Read-type commands only need their header to be complete, and the host may stop the data-out phase after any bit. Array access, the write enable latch and the status register live downstream and act on the pulses.

The serial pins are oversampled by the system clock through a synchronizer, so SCLK high and low phases must each last at least four system clock cycles. The serial output is presented as a data bit plus an output enable for the pad.

Top module: `spi_flash_cmd_frontend`

## Requirements
- R1: Serial input is sampled on each SCLK rising edge while chip select is low, bytes are assembled MSB first, and the first complete byte of a frame appears on `cmd_opcode` with a one-cycle `cmd_opcode_vld` pulse.
- R2: For opcodes 03h, 0Bh, 02h, 20h and D8h, bytes 2 to 4 of the frame are loaded into `cmd_addr` MSB first (byte 2 ends up in bits 23:16).
- R3: For page program (02h, four header bytes) and status write (01h, one header byte), each complete byte after the header produces one `cmd_data_vld` pulse carrying that byte; a trailing partial byte and every other opcode produce no data pulse.
- R4: A write-type opcode (06h, 04h, 01h, 02h, 20h, D8h, C7h) gets `cmd_exec` at chip-select rise only if the clock count is a multiple of eight and at least eight times its minimum byte count (1 for 06h, 04h, C7h; 2 for 01h; 4 for 20h, D8h; 5 for 02h); otherwise it gets `cmd_reject`.
- R5: A read-type opcode (05h, 9Fh with 1 header byte; 03h with 4; 0Bh with 5, the last being a dummy byte) gets `cmd_exec` whenever its header bytes are complete, however many further bits were clocked.
- R6: A frame with at least one clock but fewer than eight, or with an opcode not listed in R4 or R5, is rejected; a frame with no clock at all produces neither pulse.
- R7: Each frame produces at most one of `cmd_exec` and `cmd_reject`, never both at once, and only after chip select has risen.
- R8: During the data-out phase of a read-type opcode, `spi_miso` changes only after SCLK falling edges and carries bytes taken from `tx_data` MSB first; a `tx_req` pulse marks each byte taken, and the first bit is valid before the first data-out rising edge.
- R9: `spi_miso_oe` is low while chip select is high and high while it is low.
- R10: All framing state (bit count, byte count, opcode-captured flag, data-out phase) is cleared while chip select is high, so back-to-back frames are judged independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| cmd_opcode | output | 8 | Opcode of the current or last frame |
| cmd_opcode_vld | output | 1 | Pulse when an opcode is captured |
| cmd_addr | output | 24 | Address assembled from the frame |
| cmd_data | output | 8 | Data byte accompanying `cmd_data_vld` |
| cmd_data_vld | output | 1 | Pulse per complete data byte |
| cmd_exec | output | 1 | Pulse: frame accepted |
| cmd_reject | output | 1 | Pulse: frame rejected |
| tx_data | input | 8 | Next byte to send in the data-out phase |
| tx_req | output | 1 | Pulse when `tx_data` has been taken |

## Verification
On every cycle the assertions check that verdict pulses are exclusive and follow a chip-select rise, that an accepted write-type frame ended on a byte boundary, that data strobes appear only for the two data-carrying opcodes, that the bit counter and serial output move only on their own clock edges, and that the output enable is off while deselected. Only the bench scenarios can show the arithmetic of the verdict against every opcode and many clock counts, the address and data byte values, and the exact bit sequence returned during reads, since these depend on whole frames rather than single-cycle relations.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int ADDR_BYTES = 3;
    localparam int ADDR_W     = 8 * ADDR_BYTES;

    localparam logic [7:0] OP_WR_EN    = 8'h06;
    localparam logic [7:0] OP_WR_DIS   = 8'h04;
    localparam logic [7:0] OP_RD_STAT  = 8'h05;
    localparam logic [7:0] OP_WR_STAT  = 8'h01;
    localparam logic [7:0] OP_RD_ARR   = 8'h03;
    localparam logic [7:0] OP_RD_FAST  = 8'h0B;
    localparam logic [7:0] OP_RD_IDENT = 8'h9F;
    localparam logic [7:0] OP_PROG     = 8'h02;
    localparam logic [7:0] OP_ERASE_SM = 8'h20;
    localparam logic [7:0] OP_ERASE_LG = 8'hD8;
    localparam logic [7:0] OP_ERASE_ALL= 8'hC7;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2
    } cmd_kind_e;

    // min_bytes: bytes a frame must contain to be accepted
    // hdr_bytes: index of the first data byte (data-carrying opcodes)
    typedef struct packed {
        cmd_kind_e  kind;
        logic [2:0] min_bytes;
        logic       has_addr;
        logic       takes_data;
        logic [2:0] hdr_bytes;
    } cmd_info_t;

    function automatic cmd_info_t decode_op(input logic [7:0] op);
        cmd_info_t inf;
        inf = '{kind: KIND_NONE, min_bytes: 3'd0, has_addr: 1'b0,
                takes_data: 1'b0, hdr_bytes: 3'd0};
        case (op)
            OP_WR_EN, OP_WR_DIS, OP_ERASE_ALL:
                inf = '{KIND_WRITE, 3'd1, 1'b0, 1'b0, 3'd0};
            OP_RD_STAT, OP_RD_IDENT:
                inf = '{KIND_READ, 3'd1, 1'b0, 1'b0, 3'd0};
            OP_WR_STAT:
                inf = '{KIND_WRITE, 3'd2, 1'b0, 1'b1, 3'd1};
            OP_RD_ARR:
                inf = '{KIND_READ, 3'd4, 1'b1, 1'b0, 3'd0};
            OP_RD_FAST:
                inf = '{KIND_READ, 3'd5, 1'b1, 1'b0, 3'd0};
            OP_PROG:
                inf = '{KIND_WRITE, 3'd5, 1'b1, 1'b1, 3'd4};
            OP_ERASE_SM, OP_ERASE_LG:
                inf = '{KIND_WRITE, 3'd4, 1'b1, 1'b0, 3'd0};
            default: ;
        endcase
        return inf;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_raw,
    input  logic cs_n_raw,
    input  logic mosi_raw,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_high,
    output logic cs_rise,
    output logic mosi_s
);
    // channel order inside each stage: {mosi, cs_n, sclk}
    localparam int         CH       = 3;
    localparam logic [2:0] IDLE_VAL = 3'b010;

    typedef struct packed {
        logic [STAGES-1:0][CH-1:0] stg;
        logic [1:0]                prev;   // {cs_n, sclk} one stage later
    } sync_t;

    sync_t q, d;

    always_comb begin
        d = q;
        for (int i = 0; i < STAGES; i++) begin
            if (i == 0) d.stg[i] = {mosi_raw, cs_n_raw, sclk_raw};
            else        d.stg[i] = q.stg[i-1];
        end
        d.prev = q.stg[STAGES-1][1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.stg  <= {STAGES{IDLE_VAL}};
            q.prev <= IDLE_VAL[1:0];
        end else begin
            q <= d;
        end
    end

    logic [CH-1:0] cur;
    assign cur       = q.stg[STAGES-1];
    assign cs_high   = cur[1];
    assign cs_rise   = cur[1] & ~q.prev[1];
    assign sclk_rise = cur[0] & ~q.prev[0] & ~cur[1];
    assign sclk_fall = ~cur[0] & q.prev[0];
    assign mosi_s    = cur[2];

endmodule

// File: rtl/spi_rx_framer.sv
module spi_rx_framer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_high,
    input  logic             sclk_rise,
    input  logic             mosi_s,
    output logic             byte_done,
    output logic [7:0]       rx_byte,
    output logic [CNT_W-1:0] done_idx,
    output logic [2:0]       bit_idx,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             seen_clk
);
    typedef struct packed {
        logic [6:0]       shift;
        logic [2:0]       bit_idx;
        logic [CNT_W-1:0] byte_cnt;
        logic             byte_done;
        logic [7:0]       rx_byte;
        logic [CNT_W-1:0] done_idx;
        logic             seen;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d = q;
        d.byte_done = 1'b0;
        if (cs_high) begin
            d.shift    = '0;
            d.bit_idx  = '0;
            d.byte_cnt = '0;
            d.seen     = 1'b0;
        end else if (sclk_rise) begin
            d.seen    = 1'b1;
            d.shift   = {q.shift[5:0], mosi_s};
            d.bit_idx = q.bit_idx + 3'd1;
            if (q.bit_idx == 3'd7) begin
                d.byte_done = 1'b1;
                d.rx_byte   = {q.shift, mosi_s};
                d.done_idx  = q.byte_cnt;
                if (q.byte_cnt != '1) d.byte_cnt = q.byte_cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_done = q.byte_done;
    assign rx_byte   = q.rx_byte;
    assign done_idx  = q.done_idx;
    assign bit_idx   = q.bit_idx;
    assign byte_cnt  = q.byte_cnt;
    assign seen_clk  = q.seen;

    // R1: the bit position only moves on a sampled rising edge or a deselect clear
    assert_bit_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.bit_idx) |-> ($past(sclk_rise) || $past(cs_high)));

    // R10: while deselected for two cycles, no clock has been counted
    assert_clear_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_high && $past(cs_high)) |-> (!q.seen && q.byte_cnt == '0));

endmodule

// File: rtl/spi_cmd_tracker.sv
module spi_cmd_tracker
    import spi_cmd_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_high,
    input  logic              cs_rise,
    input  logic              byte_done,
    input  logic [7:0]        rx_byte,
    input  logic [CNT_W-1:0]  done_idx,
    input  logic [2:0]        bit_idx,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              seen_clk,
    output logic [7:0]        opcode,
    output logic              opcode_vld,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        data_byte,
    output logic              data_vld,
    output logic              dout_phase,
    output logic              exec,
    output logic              reject
);
    typedef struct packed {
        logic [7:0]        opcode;
        logic              op_vld;
        logic              have_op;
        cmd_info_t         info;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data_byte;
        logic              data_vld;
        logic              dout;
        logic              exec;
        logic              reject;
    } trk_t;

    trk_t      q, d;
    cmd_info_t new_info;
    logic      complete;
    logic      accept;

    always_comb begin
        d          = q;
        d.op_vld   = 1'b0;
        d.data_vld = 1'b0;
        d.exec     = 1'b0;
        d.reject   = 1'b0;
        new_info   = decode_op(rx_byte);
        complete   = q.have_op && (q.info.kind != KIND_NONE) &&
                     (byte_cnt >= CNT_W'(q.info.min_bytes));
        accept     = complete && ((q.info.kind == KIND_READ) || (bit_idx == 3'd0));

        if (cs_rise && seen_clk) begin
            d.exec   = accept;
            d.reject = !accept;
        end

        if (cs_high) begin
            d.have_op = 1'b0;
            d.dout    = 1'b0;
            d.info    = '0;
        end else if (byte_done) begin
            if (done_idx == '0) begin
                d.opcode  = rx_byte;
                d.op_vld  = 1'b1;
                d.have_op = 1'b1;
                d.info    = new_info;
                d.dout    = (new_info.kind == KIND_READ) && (new_info.min_bytes == 3'd1);
            end else begin
                if (q.info.has_addr && (done_idx <= CNT_W'(ADDR_BYTES)))
                    d.addr = {q.addr[ADDR_W-9:0], rx_byte};
                if (q.info.takes_data && (done_idx >= CNT_W'(q.info.hdr_bytes))) begin
                    d.data_vld  = 1'b1;
                    d.data_byte = rx_byte;
                end
                if ((q.info.kind == KIND_READ) &&
                    ((done_idx + CNT_W'(1)) == CNT_W'(q.info.min_bytes)))
                    d.dout = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign opcode     = q.opcode;
    assign opcode_vld = q.op_vld;
    assign addr       = q.addr;
    assign data_byte  = q.data_byte;
    assign data_vld   = q.data_vld;
    assign dout_phase = q.dout;
    assign exec       = q.exec;
    assign reject     = q.reject;

    // R7: one verdict at a time, and only after chip select rose
    assert_single_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.exec && q.reject));
    assert_verdict_after_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.exec || q.reject) |-> $past(cs_rise));

    // R4: an accepted write-type frame ended on a byte boundary
    assert_write_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.exec && ($past(q.info.kind) == KIND_WRITE)) |-> ($past(bit_idx) == 3'd0));

    // R3: data strobes belong to the two data-carrying opcodes only
    assert_data_opcode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.data_vld |-> ((q.opcode == OP_PROG) || (q.opcode == OP_WR_STAT)));

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_high,
    input  logic       sclk_fall,
    input  logic       dout_phase,
    input  logic [7:0] tx_data,
    output logic       tx_req,
    output logic       miso,
    output logic       miso_oe
);
    typedef struct packed {
        logic [6:0] shift;
        logic [2:0] ptr;
        logic       miso;
        logic       oe;
        logic       req;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d     = q;
        d.req = 1'b0;
        d.oe  = !cs_high;
        if (cs_high) begin
            d.ptr  = '0;
            d.miso = 1'b0;
        end else if (sclk_fall && dout_phase) begin
            if (q.ptr == 3'd0) begin
                d.miso  = tx_data[7];
                d.shift = tx_data[6:0];
                d.req   = 1'b1;
            end else begin
                d.miso  = q.shift[6];
                d.shift = {q.shift[5:0], 1'b0};
            end
            d.ptr = q.ptr + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tx_req  = q.req;
    assign miso    = q.miso;
    assign miso_oe = q.oe;

    // R8: the output bit moves only after a falling edge or a deselect clear
    assert_miso_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.miso) |-> ($past(sclk_fall) || $past(cs_high)));

    // R9: no drive while deselected
    assert_oe_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_high && $past(cs_high)) |-> !q.oe);

endmodule

// File: rtl/spi_flash_cmd_frontend.sv
module spi_flash_cmd_frontend
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [7:0]        cmd_opcode,
    output logic              cmd_opcode_vld,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [7:0]        cmd_data,
    output logic              cmd_data_vld,
    output logic              cmd_exec,
    output logic              cmd_reject,
    input  logic [7:0]        tx_data,
    output logic              tx_req
);
    logic             sclk_rise, sclk_fall, cs_high, cs_rise, mosi_s;
    logic             byte_done, seen_clk, dout_phase;
    logic [7:0]       rx_byte;
    logic [CNT_W-1:0] done_idx, byte_cnt;
    logic [2:0]       bit_idx;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_raw  (spi_sclk),
        .cs_n_raw  (spi_cs_n),
        .mosi_raw  (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_high   (cs_high),
        .cs_rise   (cs_rise),
        .mosi_s    (mosi_s)
    );

    spi_rx_framer #(.CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_high   (cs_high),
        .sclk_rise (sclk_rise),
        .mosi_s    (mosi_s),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .done_idx  (done_idx),
        .bit_idx   (bit_idx),
        .byte_cnt  (byte_cnt),
        .seen_clk  (seen_clk)
    );

    spi_cmd_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_high    (cs_high),
        .cs_rise    (cs_rise),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .done_idx   (done_idx),
        .bit_idx    (bit_idx),
        .byte_cnt   (byte_cnt),
        .seen_clk   (seen_clk),
        .opcode     (cmd_opcode),
        .opcode_vld (cmd_opcode_vld),
        .addr       (cmd_addr),
        .data_byte  (cmd_data),
        .data_vld   (cmd_data_vld),
        .dout_phase (dout_phase),
        .exec       (cmd_exec),
        .reject     (cmd_reject)
    );

    spi_tx_shifter u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_high    (cs_high),
        .sclk_fall  (sclk_fall),
        .dout_phase (dout_phase),
        .tx_data    (tx_data),
        .tx_req     (tx_req),
        .miso       (spi_miso),
        .miso_oe    (spi_miso_oe)
    );

endmodule

// File: tb/spi_flash_cmd_frontend_tb.sv
module spi_flash_cmd_frontend_tb;

    localparam int HALF  = 8;        // system clocks per SCLK phase
    localparam int LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe;
    logic [7:0]  cmd_opcode, cmd_data, tx_data;
    logic        cmd_opcode_vld, cmd_data_vld, cmd_exec, cmd_reject, tx_req;
    logic [23:0] cmd_addr;

    int n_checks = 0;
    int n_fail   = 0;
    int n_exec   = 0;
    int n_rej    = 0;
    int n_data   = 0;
    int tx_idx   = 0;
    int cyc      = 0;
    bit finished = 0;
    logic [7:0] data_log [64];

    always #5 clk = ~clk;

    spi_flash_cmd_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .cmd_opcode(cmd_opcode), .cmd_opcode_vld(cmd_opcode_vld),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_data_vld(cmd_data_vld),
        .cmd_exec(cmd_exec), .cmd_reject(cmd_reject), .tx_data(tx_data),
        .tx_req(tx_req)
    );

    function automatic logic [7:0] fb(input logic [7:0] op, input int k);
        return (k == 0) ? op : 8'(k * 53 + int'(op) + 7);
    endfunction

    function automatic logic [7:0] txf(input int i);
        return 8'(i * 29 + 3);
    endfunction

    // bench view of the opcode table from R4/R5/R3/R2
    function automatic int min_bytes(input logic [7:0] op);
        case (op)
            8'h06, 8'h04, 8'hC7, 8'h05, 8'h9F: return 1;
            8'h01: return 2;
            8'h03, 8'h20, 8'hD8: return 4;
            8'h0B, 8'h02: return 5;
            default: return 0;
        endcase
    endfunction
    function automatic bit is_read(input logic [7:0] op);
        return (op == 8'h05 || op == 8'h9F || op == 8'h03 || op == 8'h0B);
    endfunction
    function automatic bit has_addr(input logic [7:0] op);
        return (op == 8'h03 || op == 8'h0B || op == 8'h02 || op == 8'h20 || op == 8'hD8);
    endfunction
    function automatic int data_hdr(input logic [7:0] op);
        return (op == 8'h02) ? 4 : (op == 8'h01) ? 1 : -1;
    endfunction

    // pulse monitor and array-side byte source
    always @(negedge clk) begin
        cyc++;
        if (cmd_exec)   n_exec++;
        if (cmd_reject) n_rej++;
        if (cmd_data_vld) begin
            data_log[n_data % 64] = cmd_data;
            n_data++;
        end
        if (spi_cs_n)    tx_idx = 0;
        else if (tx_req) tx_idx++;
        tx_data = txf(tx_idx);
        if (cyc > LIMIT && !finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_frame(input logic [7:0] op, input int nbits);
        int  e0 = n_exec;
        int  r0 = n_rej;
        int  d0 = n_data;
        int  mb = min_bytes(op);
        int  dout_bit = is_read(op) ? 8 * mb : -1;
        int  bad = 0;
        bit  exp_ok;
        int  exp_data;
        spi_cs_n = 1'b0;
        wait_clk(HALF);
        for (int b = 0; b < nbits; b++) begin
            logic [7:0] cur;
            logic [7:0] tb_byte;
            int j;
            cur = fb(op, b / 8);
            spi_sclk = 1'b0;
            spi_mosi = cur[7 - (b % 8)];
            wait_clk(HALF);
            if (dout_bit >= 0 && b >= dout_bit) begin
                j = b - dout_bit;
                tb_byte = txf(j / 8);
                if (spi_miso !== tb_byte[7 - (j % 8)] || spi_miso_oe !== 1'b1) bad++;
            end
            spi_sclk = 1'b1;
            wait_clk(HALF);
        end
        spi_sclk = 1'b0;
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(12);

        // R4, R5, R6, R7: verdict arithmetic
        if (nbits == 0)
            check((n_exec - e0) == 0 && (n_rej - r0) == 0, "R6 no-clock frame",
                  (n_exec - e0) + (n_rej - r0), 0);
        else begin
            if (mb == 0 || nbits < 8)  exp_ok = 0;
            else if (is_read(op))      exp_ok = (nbits >= 8 * mb);
            else                       exp_ok = (nbits % 8 == 0) && (nbits >= 8 * mb);
            check((n_exec - e0) == int'(exp_ok) && (n_rej - r0) == int'(!exp_ok),
                  is_read(op) ? "R5 read verdict" : (mb == 0 ? "R6 unknown opcode" : "R4 write verdict"),
                  (n_exec - e0) * 10 + (n_rej - r0), int'(exp_ok) * 10 + int'(!exp_ok));
        end
        if (nbits >= 8)
            check(cmd_opcode == op, "R1 opcode capture", int'(cmd_opcode), int'(op));
        if (has_addr(op) && nbits >= 32)
            check(cmd_addr == {fb(op, 1), fb(op, 2), fb(op, 3)}, "R2 address",
                  int'(cmd_addr), int'({fb(op, 1), fb(op, 2), fb(op, 3)}));
        exp_data = 0;
        if (data_hdr(op) >= 0 && nbits / 8 > data_hdr(op)) exp_data = nbits / 8 - data_hdr(op);
        check((n_data - d0) == exp_data, "R3 data strobe count", n_data - d0, exp_data);
        for (int i = 0; i < exp_data && (n_data - d0) == exp_data; i++)
            check(data_log[(d0 + i) % 64] == fb(op, data_hdr(op) + i), "R3 data value",
                  int'(data_log[(d0 + i) % 64]), int'(fb(op, data_hdr(op) + i)));
        if (dout_bit >= 0 && nbits > dout_bit)
            check(bad == 0, "R8 read data bits", bad, 0);
        check(spi_miso_oe == 1'b0, "R9 idle output enable", int'(spi_miso_oe), 0);
    endtask

    localparam logic [7:0] OPS [12] = '{8'h06, 8'h04, 8'h05, 8'h01, 8'h03, 8'h0B,
                                        8'h9F, 8'h02, 8'h20, 8'hD8, 8'hC7, 8'hA5};
    localparam int NBITS [16] = '{1, 7, 8, 9, 15, 16, 17, 24, 31, 32, 33, 39, 40, 41, 47, 48};

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        // reset state
        check(cmd_exec == 0 && cmd_reject == 0, "R7 reset verdict", int'(cmd_exec), 0);
        check(spi_miso_oe == 0, "R9 reset output enable", int'(spi_miso_oe), 0);
        check(cmd_opcode == 8'h00, "R1 reset opcode", int'(cmd_opcode), 0);

        // chip select pulse with no clock
        run_frame(8'h06, 0);

        // sweep every opcode against clock counts around byte boundaries;
        // consecutive frames also show the R10 clear between frames
        foreach (OPS[o]) begin
            foreach (NBITS[n]) begin
                run_frame(OPS[o], NBITS[n]);
            end
        end

        // R10: a rejected partial frame does not leak into the next one
        run_frame(8'h20, 29);
        run_frame(8'h06, 8);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule